// File: doc/BRIEF.md
# Outbound Posted Write Queue Controller

This block takes posted write transactions from an internal system-bus target port and hands them to an external bus master. It keeps each write's address in an address queue. Its data beats, with their byte enables, go into a separate data buffer that is tied one to one to that address slot. In the cycle a write starts, the block decides whether to claim it and accept it, or to answer with a retry. A single-address write is claimed only when its address falls inside one of two programmable outbound windows. A dual-address write is always claimed.

Once a write is accepted, its beats are stored from the word offset of the start address onward. Storing stops when the initiator marks the last beat or when the last word of the 64-byte buffer is written. On that boundary the initiator is disconnected, and the rest of its burst must come back as a new transaction. Each closed entry records its address, its start word and its word count. Entries are offered to the external master strictly in order. The master reads words by index and frees the head entry with a done pulse.

Top module: `posted_wr_queue`

## Requirements
- R1: After reset no request is raised towards the external master, and neither accept nor retry is driven.
- R2: A single-address start whose low 32 address bits match window 0 or window 1 on all bits above that window's size exponent is accepted in the same cycle when a slot is free and no write is open.
- R3: A single-address start outside both windows is not claimed: no accept, no retry and no disconnect, and nothing is queued.
- R4: A dual-address start is accepted whatever its address, given a free slot and no open write, and the entry is flagged dual towards the external side.
- R5: With all four slots holding entries, every claimed start (single or dual) gets retry and no accept, and no slot contents change.
- R6: Beat n of a write is stored at word index (start address bits [5:2]) + n of its buffer, with its byte enables unchanged. The entry reports that start word and a length equal to the number of stored beats.
- R7: The beat written to word 15 of a buffer gets disconnect in the same cycle, and the entry is closed with length 16 minus its start word.
- R8: The external request for an entry rises in the cycle after its closing beat (last marker or word 15), and not before.
- R9: Entries are presented in acceptance order. A done pulse while the request is high frees exactly the head entry.
- R10: A claimed start that arrives while a write is still open gets retry and no accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win0_base | input | 32 | Window 0 base address |
| win0_lg | input | 5 | Window 0 size as a power of two of bytes |
| win1_base | input | 32 | Window 1 base address |
| win1_lg | input | 5 | Window 1 size as a power of two of bytes |
| in_start | input | 1 | Address phase of a new internal write |
| in_dual | input | 1 | The write uses a dual address cycle |
| in_addr | input | 64 | Write start address |
| in_beat | input | 1 | A data beat is present |
| in_data | input | 32 | Beat data |
| in_be | input | 4 | Beat byte enables |
| in_last | input | 1 | Final beat of the internal write |
| in_accept | output | 1 | Start claimed and accepted |
| in_retry | output | 1 | Start claimed but refused, initiator must retry |
| in_disc | output | 1 | Beat hit the buffer boundary, initiator disconnected |
| ex_req | output | 1 | Head entry is complete and ready for the external bus |
| ex_addr | output | 64 | Head entry address |
| ex_dual | output | 1 | Head entry used a dual address cycle |
| ex_off | output | 4 | Head entry start word in its buffer |
| ex_len | output | 5 | Head entry word count |
| ex_sel | input | 4 | Word index read from the head buffer |
| ex_data | output | 32 | Head buffer word at ex_sel |
| ex_be | output | 4 | Byte enables of that word |
| ex_done | input | 1 | External master finished the head entry |

## Verification
Accept, retry and disconnect are combinational answers to the start or beat of the same cycle. The bench drives each input on a falling edge and reads these answers one time step later, before the rising edge that registers them. The external request and the head-entry fields change on the rising edge after the closing beat or the done pulse, so they are read on the following falling edge. Head data is combinational in ex_sel and is read one step after the index is set. A check just before the closing beat confirms that the request has not yet risen.

// File: rtl/posted_wr_queue.sv
module posted_wr_queue #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int BUF_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       win0_base,
  input  logic [4:0]        win0_lg,
  input  logic [31:0]       win1_base,
  input  logic [4:0]        win1_lg,
  input  logic              in_start,
  input  logic              in_dual,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_beat,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W/8-1:0] in_be,
  input  logic              in_last,
  output logic              in_accept,
  output logic              in_retry,
  output logic              in_disc,
  output logic              ex_req,
  output logic [ADDR_W-1:0] ex_addr,
  output logic              ex_dual,
  output logic [$clog2(BUF_WORDS)-1:0] ex_off,
  output logic [$clog2(BUF_WORDS):0]   ex_len,
  input  logic [$clog2(BUF_WORDS)-1:0] ex_sel,
  output logic [DATA_W-1:0] ex_data,
  output logic [DATA_W/8-1:0] ex_be,
  input  logic              ex_done
);
  localparam int PW   = $clog2(DEPTH);
  localparam int OW   = $clog2(BUF_WORDS);
  localparam int LW   = OW + 1;
  localparam int BE_W = DATA_W / 8;
  localparam int BB   = $clog2(BE_W);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic              dual_q [DEPTH];
  logic [OW-1:0]     off_q  [DEPTH];
  logic [LW-1:0]     len_q  [DEPTH];
  logic [DEPTH-1:0]  rdy_q;
  logic [DATA_W-1:0] dmem [DEPTH*BUF_WORDS];
  logic [BE_W-1:0]   bmem [DEPTH*BUF_WORDS];

  logic [PW-1:0] wp, rp;
  logic [PW:0]   used;
  logic          active;
  logic [OW-1:0] cur_off;
  logic [LW-1:0] cur_len;

  logic sac_hit, claim, full, pop, close;
  logic [OW-1:0] word;

  assign sac_hit = ((in_addr[31:0] >> win0_lg) == (win0_base >> win0_lg)) |
                   ((in_addr[31:0] >> win1_lg) == (win1_base >> win1_lg));
  assign claim     = in_start & (in_dual | sac_hit);
  assign full      = (used == DEPTH[PW:0]);
  assign in_accept = claim & ~full & ~active;
  assign in_retry  = claim & (full | active);
  assign word      = cur_off + cur_len[OW-1:0];
  assign in_disc   = active & in_beat & (word == {OW{1'b1}});
  assign close     = active & in_beat & (in_last | (word == {OW{1'b1}}));
  assign ex_req    = rdy_q[rp];
  assign pop       = ex_done & ex_req;

  assign ex_addr = addr_q[rp];
  assign ex_dual = dual_q[rp];
  assign ex_off  = off_q[rp];
  assign ex_len  = len_q[rp];
  assign ex_data = dmem[{rp, ex_sel}];
  assign ex_be   = bmem[{rp, ex_sel}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      used    <= '0;
      active  <= 1'b0;
      cur_off <= '0;
      cur_len <= '0;
      rdy_q   <= '0;
    end else begin
      used <= used + {{PW{1'b0}}, in_accept} - {{PW{1'b0}}, pop};
      if (in_accept) begin
        active  <= 1'b1;
        cur_off <= in_addr[BB +: OW];
        cur_len <= '0;
      end
      if (active && in_beat) begin
        cur_len <= cur_len + 1'b1;
        if (close) begin
          rdy_q[wp] <= 1'b1;
          wp        <= wp + 1'b1;
          active    <= 1'b0;
        end
      end
      if (pop) begin
        rdy_q[rp] <= 1'b0;
        rp        <= rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_accept) begin
      addr_q[wp] <= in_addr;
      dual_q[wp] <= in_dual;
      off_q[wp]  <= in_addr[BB +: OW];
    end
    if (close) len_q[wp] <= cur_len + 1'b1;
    if (active && in_beat) begin
      dmem[{wp, word}] <= in_data;
      bmem[{wp, word}] <= in_be;
    end
  end

  // R10
  accept_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_accept && in_retry));
  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH[PW:0]);
  // R8
  req_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_req |-> (used != '0));
  // R2
  accept_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_accept |=> active);
  // R7
  disc_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_disc |=> !active);
  // R9
  pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !in_accept) |=> (used == $past(used) - 1'b1));
endmodule

// File: tb/posted_wr_queue_bench.sv
module posted_wr_queue_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] win0_base = 32'h1000_0000, win1_base = 32'h8000_0000;
  logic [4:0]  win0_lg = 5'd20, win1_lg = 5'd16;
  logic        in_start = 0, in_dual = 0, in_beat = 0, in_last = 0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic        in_accept, in_retry, in_disc, ex_req, ex_dual;
  logic [63:0] ex_addr;
  logic [3:0]  ex_off, ex_sel = '0, ex_be;
  logic [4:0]  ex_len;
  logic [31:0] ex_data;
  logic        ex_done = 0;

  int total = 0, bad = 0;
  logic g_acc, g_rty, g_disc;

  posted_wr_queue u_posted_wr_queue (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [64:0] VEC [6] = '{
    {1'b1, 64'h0000_0000_1000_0040},
    {1'b1, 64'h0000_0000_100F_FFC0},
    {1'b0, 64'h0000_0000_1010_0000},
    {1'b1, 64'h0000_0000_8000_1000},
    {1'b0, 64'h0000_0000_8001_0000},
    {1'b0, 64'h0000_0000_0FFF_FFFC}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [63:0] a, input bit d);
    in_start = 1; in_dual = d; in_addr = a;
    #1 g_acc = in_accept; g_rty = in_retry;
    @(negedge clk);
    in_start = 0; in_dual = 0;
  endtask

  task automatic beat(input logic [31:0] dt, input logic [3:0] be, input bit last);
    in_beat = 1; in_data = dt; in_be = be; in_last = last;
    #1 g_disc = in_disc;
    @(negedge clk);
    in_beat = 0; in_last = 0;
  endtask

  task automatic drain(input logic [63:0] a, input logic [4:0] len, input string req);
    chk(ex_req == 1'b1, req, "req before drain", 64'(ex_req), 64'd1);
    chk(ex_addr == a, req, "head addr", ex_addr, a);
    chk(ex_len == len, req, "head len", 64'(ex_len), 64'(len));
    ex_done = 1;
    @(negedge clk);
    ex_done = 0;
  endtask

  task automatic read_word(input logic [3:0] s, input logic [31:0] dt,
                           input logic [3:0] be, input string req);
    ex_sel = s;
    #1;
    chk(ex_data == dt, req, "word data", 64'(ex_data), 64'(dt));
    chk(ex_be == be, req, "word be", 64'(ex_be), 64'(be));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ex_req == 0, "R1", "req after reset", 64'(ex_req), 0);
    chk(in_accept == 0 && in_retry == 0, "R1", "accept/retry idle",
        64'({in_accept, in_retry}), 0);

    // R2 / R3 window decode table
    foreach (VEC[i]) begin
      start(VEC[i][63:0], 0);
      chk(g_acc == VEC[i][64], VEC[i][64] ? "R2" : "R3", "accept", 64'(g_acc), 64'(VEC[i][64]));
      chk(g_rty == 0, "R3", "no retry", 64'(g_rty), 0);
      if (VEC[i][64]) begin
        beat(32'hA5A5_0000 + 32'(i), 4'hF, 1);
        chk(g_disc == 0, "R2", "no disc", 64'(g_disc), 0);
        chk(ex_dual == 0, "R2", "sac flag", 64'(ex_dual), 0);
        drain(VEC[i][63:0], 5'd1, "R2");
      end else begin
        beat(32'h0, 4'hF, 1);
        chk(g_disc == 0, "R3", "no disc on miss", 64'(g_disc), 0);
        chk(ex_req == 0, "R3", "nothing queued", 64'(ex_req), 0);
      end
    end

    // R4 dual address outside windows
    start(64'h0000_0042_0000_0000, 1);
    chk(g_acc == 1, "R4", "dual accept", 64'(g_acc), 1);
    beat(32'h1234_5678, 4'hF, 1);
    chk(ex_dual == 1, "R4", "dual flag", 64'(ex_dual), 1);
    drain(64'h0000_0042_0000_0000, 5'd1, "R4");

    // R6 / R8 burst at offset 2
    start(64'h1000_0008, 0);
    beat(32'hB000_0001, 4'h3, 0);
    beat(32'hB000_0002, 4'hF, 0);
    chk(ex_req == 0, "R8", "no req while open", 64'(ex_req), 0);
    beat(32'hB000_0003, 4'h8, 1);
    chk(ex_req == 1, "R8", "req after close", 64'(ex_req), 1);
    chk(ex_off == 4'd2, "R6", "start word", 64'(ex_off), 2);
    read_word(4'd2, 32'hB000_0001, 4'h3, "R6");
    read_word(4'd3, 32'hB000_0002, 4'hF, "R6");
    read_word(4'd4, 32'hB000_0003, 4'h8, "R6");
    drain(64'h1000_0008, 5'd3, "R6");

    // R7 boundary disconnect, then continuation; R9 order
    start(64'h1000_0030, 0);
    for (int k = 0; k < 4; k++) begin
      beat(32'hC000_0000 + 32'(k), 4'hF, 0);
      chk(g_disc == (k == 3), "R7", "disc at word 15", 64'(g_disc), 64'(k == 3));
    end
    start(64'h1000_0040, 0);
    chk(g_acc == 1, "R7", "continuation accepted", 64'(g_acc), 1);
    beat(32'hC000_0004, 4'hF, 1);
    read_word(4'd15, 32'hC000_0003, 4'hF, "R7");
    drain(64'h1000_0030, 5'd4, "R7");
    drain(64'h1000_0040, 5'd1, "R9");
    chk(ex_req == 0, "R9", "empty after drain", 64'(ex_req), 0);

    // R5 full queue
    for (int k = 0; k < 4; k++) begin
      start(64'h1000_0100 + 64'(k * 64), 0);
      beat(32'hD000_0000 + 32'(k), 4'hF, 1);
    end
    start(64'h1000_0400, 0);
    chk(g_rty == 1 && g_acc == 0, "R5", "sac retry when full", 64'({g_acc, g_rty}), 1);
    beat(32'hEEEE_EEEE, 4'hF, 1);
    start(64'h0000_0099_0000_0000, 1);
    chk(g_rty == 1 && g_acc == 0, "R5", "dac retry when full", 64'({g_acc, g_rty}), 1);
    for (int k = 0; k < 4; k++) begin
      read_word(4'd0, 32'hD000_0000 + 32'(k), 4'hF, "R5");
      drain(64'h1000_0100 + 64'(k * 64), 5'd1, "R9");
    end
    chk(ex_req == 0, "R5", "nothing extra stored", 64'(ex_req), 0);

    // R10 start during open write
    start(64'h1000_0200, 0);
    start(64'h1000_0240, 0);
    chk(g_rty == 1 && g_acc == 0, "R10", "retry while open", 64'({g_acc, g_rty}), 1);
    beat(32'hF00D_0000, 4'hF, 1);
    drain(64'h1000_0200, 5'd1, "R10");
    chk(ex_req == 0, "R10", "second start not queued", 64'(ex_req), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule